// File: doc/BRIEF.md
# I2C Master Bit-Timing Engine

This block produces the SCL waveform and places every SDA transition for an I2C master. A controller above it issues one bus operation at a time: start, stop, send one bit or receive one bit. The engine carries out the operation with timing set entirely by programmed values. These are a low divider and a high divider, a data-update setting and two setup multipliers, one for start and one for stop. It raises a one-clock completion strobe when the operation ends. Both lines are open-drain. The block only reports when it wants to pull a line low, and it reads the resolved line levels back.

Each SCL half-period is measured in units of eight input clocks, scaled by the corresponding divider plus one. The SDA change point inside the low phase scales by its own multiplier. The start and stop setup and hold windows also scale by their own multipliers. Received data is taken at the middle of the high phase. A two-bit status output shows which of the two lines is currently held low. A start is refused unless both lines are high. Timing values are copied into shadow storage when a start is accepted, so reprogramming during a transfer has no effect until the next start.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset, scl_oe, sda_oe, rx_bit, done and err are all 0.
- R2: With l = cfg_div[15:0]+1 and h = cfg_div[31:16]+1, a bit operation accepted at clock edge 0 releases SCL at edge 8·l and pulls it low again at edge 8·(l+h), where it completes. A bit operation is cmd_op 2 (send cmd_bit) or 3 (receive).
- R3: During a bit or stop operation, SDA takes its new value at edge l·s+1, where s = cfg_upd+1. A cfg_upd value of 3 acts as 2.
- R4: A start (cmd_op 0) accepted at edge 0 pulls SDA low at edge 8·h·u+1, with u = cfg_sta+1. It pulls SCL low a further 8·h·(u+1)−1 edges later and completes there.
- R5: A stop (cmd_op 1) pulls SDA low at edge l·s+1 and releases SCL at edge 8·l. It releases SDA a further 8·h·p+1 edges after that and completes there, with p = cfg_sto+1.
- R6: A receive operation samples the SDA line 4·h edges after SCL is released. The value appears on rx_bit and holds until the next receive sample.
- R7: done is high for exactly one clock after the edge that makes the final line change of an operation.
- R8: pin_state bit 0 is 1 when the SDA line is low and bit 1 is 1 when the SCL line is low. The value 0 means both lines are high.
- R9: A start while pin_state is not 0 is refused, as is a stop or bit operation issued without a prior completed start. A refused command pulses err for one clock and leaves both line enables unchanged.
- R10: Divider and timing fields are captured only when a start is accepted. Values changed afterwards do not alter later bit or stop operations of the same transfer.
- R11: A command presented while an operation is in progress is ignored. It neither changes that operation's timing nor starts afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all timing counts this clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 32 | High divider in [31:16], low divider in [15:0] |
| cfg_upd | input | 2 | SDA update-point multiplier minus one (0..2, 3 treated as 2) |
| cfg_sta | input | 2 | Start setup multiplier minus one |
| cfg_sto | input | 2 | Stop setup multiplier minus one |
| cmd_valid | input | 1 | Command request, taken when the engine is idle |
| cmd_op | input | 2 | 0 start, 1 stop, 2 send bit, 3 receive bit |
| cmd_bit | input | 1 | Bit value for a send operation |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_bit | output | 1 | Last received bit |
| done | output | 1 | One-clock completion strobe |
| err | output | 1 | One-clock refusal strobe |
| pin_state | output | 2 | Line status: bit 1 SCL low, bit 0 SDA low |

## Verification
The hardest conditions to reach are those where timing state could leak across an operation boundary. One is a divider rewritten in the middle of a transfer. Another is a second command arriving while a bit is still in flight. To reach them, the stimulus rewrites the divider and update fields between a start and the following bit. It then raises a stop request partway through a bit operation. A per-clock model of the line enables shows that neither event alters any edge. Refused starts are reached by holding a line low from outside the block, which also drives every pin_state code.

// File: rtl/i2c_tm_pkg.sv
`timescale 1ns/1ps
package i2c_tm_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_TX    = 2'd2,
        OP_RX    = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_STOP  = 2'd2,
        ST_BIT   = 2'd3
    } seq_st_e;

endpackage

// File: rtl/i2c_tm_timing.sv
`timescale 1ns/1ps
module i2c_tm_timing #(
    parameter int DIV_W = 16,
    parameter int CNT_W = DIV_W + 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [2*DIV_W-1:0] cfg_div,
    input  logic [1:0]         cfg_upd,
    input  logic [1:0]         cfg_sta,
    input  logic [1:0]         cfg_sto,
    output logic [CNT_W-1:0]   t_upd,
    output logic [CNT_W-1:0]   t_low,
    output logic [CNT_W-1:0]   t_smp,
    output logic [CNT_W-1:0]   t_bit,
    output logic [CNT_W-1:0]   t_sta_su,
    output logic [CNT_W-1:0]   t_sta_end,
    output logic [CNT_W-1:0]   t_sto_end
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] lo;
        logic [DIV_W-1:0] hi;
        logic [1:0]       upd;
        logic [1:0]       sta;
        logic [1:0]       sto;
    } shadow_t;

    shadow_t sh_d, sh_q;

    // v * (k + 1) for k in 0..3, built from shifts and one add
    function automatic logic [CNT_W-1:0] times_k1(input logic [CNT_W-1:0] v,
                                                  input logic [1:0] k);
        case (k)
            2'd0:    times_k1 = v;
            2'd1:    times_k1 = v << 1;
            2'd2:    times_k1 = (v << 1) + v;
            default: times_k1 = v << 2;
        endcase
    endfunction

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.lo  = cfg_div[DIV_W-1:0];
            sh_d.hi  = cfg_div[2*DIV_W-1:DIV_W];
            sh_d.upd = (cfg_upd == 2'd3) ? 2'd2 : cfg_upd;
            sh_d.sta = cfg_sta;
            sh_d.sto = cfg_sto;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    logic [CNT_W-1:0] l_c, h_c, l8, h8, h8u;

    always_comb begin
        l_c       = CNT_W'(sh_q.lo) + ONE;
        h_c       = CNT_W'(sh_q.hi) + ONE;
        l8        = l_c << 3;
        h8        = h_c << 3;
        h8u       = times_k1(h8, sh_q.sta);
        t_upd     = times_k1(l_c, sh_q.upd) + ONE;
        t_low     = l8;
        t_smp     = l8 + (h_c << 2);
        t_bit     = l8 + h8;
        t_sta_su  = h8u + ONE;
        t_sta_end = (h8u << 1) + h8;
        t_sto_end = l8 + times_k1(h8, sh_q.sto) + ONE;
    end

endmodule

// File: rtl/i2c_tm_pins.sv
`timescale 1ns/1ps
module i2c_tm_pins (
    input  logic       scl_in,
    input  logic       sda_in,
    output logic [1:0] pin_state,
    output logic       bus_free
);
    always_comb begin
        pin_state = {~scl_in, ~sda_in};
        bus_free  = scl_in & sda_in;
    end
endmodule

// File: rtl/i2c_tm_seq.sv
`timescale 1ns/1ps
module i2c_tm_seq
    import i2c_tm_pkg::*;
#(
    parameter int CNT_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic             cmd_bit,
    input  logic             bus_free,
    input  logic             sda_in,
    input  logic [CNT_W-1:0] t_upd,
    input  logic [CNT_W-1:0] t_low,
    input  logic [CNT_W-1:0] t_smp,
    input  logic [CNT_W-1:0] t_bit,
    input  logic [CNT_W-1:0] t_sta_su,
    input  logic [CNT_W-1:0] t_sta_end,
    input  logic [CNT_W-1:0] t_sto_end,
    output logic             load,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             rx_bit,
    output logic             done,
    output logic             err
);
    typedef struct packed {
        seq_st_e          st;
        op_e              op;
        logic             txb;
        logic             own;
        logic             scl_oe;
        logic             sda_oe;
        logic             rx;
        logic             done;
        logic             err;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic [CNT_W-1:0] nxt;
    op_e              req;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        load       = 1'b0;
        nxt        = seq_q.cnt + CNT_W'(1);
        req        = op_e'(cmd_op);
        case (seq_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    seq_d.cnt = '0;
                    if (req == OP_START) begin
                        if (bus_free) begin
                            load     = 1'b1;
                            seq_d.st = ST_START;
                        end else begin
                            seq_d.err = 1'b1;
                        end
                    end else if (seq_q.own) begin
                        seq_d.st  = (req == OP_STOP) ? ST_STOP : ST_BIT;
                        seq_d.op  = req;
                        seq_d.txb = cmd_bit;
                    end else begin
                        seq_d.err = 1'b1;
                    end
                end
            end
            ST_START: begin
                seq_d.cnt = nxt;
                if (nxt == t_sta_su) seq_d.sda_oe = 1'b1;
                if (nxt == t_sta_end) begin
                    seq_d.scl_oe = 1'b1;
                    seq_d.own    = 1'b1;
                    seq_d.done   = 1'b1;
                    seq_d.st     = ST_IDLE;
                end
            end
            ST_BIT: begin
                seq_d.cnt = nxt;
                if (nxt == t_upd)
                    seq_d.sda_oe = (seq_q.op == OP_TX) ? ~seq_q.txb : 1'b0;
                if (nxt == t_low) seq_d.scl_oe = 1'b0;
                if (nxt == t_smp && seq_q.op == OP_RX) seq_d.rx = sda_in;
                if (nxt == t_bit) begin
                    seq_d.scl_oe = 1'b1;
                    seq_d.done   = 1'b1;
                    seq_d.st     = ST_IDLE;
                end
            end
            default: begin
                seq_d.cnt = nxt;
                if (nxt == t_upd) seq_d.sda_oe = 1'b1;
                if (nxt == t_low) seq_d.scl_oe = 1'b0;
                if (nxt == t_sto_end) begin
                    seq_d.sda_oe = 1'b0;
                    seq_d.own    = 1'b0;
                    seq_d.done   = 1'b1;
                    seq_d.st     = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    always_comb begin
        scl_oe = seq_q.scl_oe;
        sda_oe = seq_q.sda_oe;
        rx_bit = seq_q.rx;
        done   = seq_q.done;
        err    = seq_q.err;
    end

endmodule

// File: rtl/i2c_bit_timer.sv
`timescale 1ns/1ps
module i2c_bit_timer #(
    parameter int DIV_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*DIV_W-1:0] cfg_div,
    input  logic [1:0]         cfg_upd,
    input  logic [1:0]         cfg_sta,
    input  logic [1:0]         cfg_sto,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic               cmd_bit,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               scl_oe,
    output logic               sda_oe,
    output logic               rx_bit,
    output logic               done,
    output logic               err,
    output logic [1:0]         pin_state
);
    localparam int CNT_W = DIV_W + 7;

    logic             load, bus_free;
    logic [CNT_W-1:0] t_upd, t_low, t_smp, t_bit, t_sta_su, t_sta_end, t_sto_end;

    i2c_tm_pins u_pins (
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .pin_state (pin_state),
        .bus_free  (bus_free)
    );

    i2c_tm_timing #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .cfg_div   (cfg_div),
        .cfg_upd   (cfg_upd),
        .cfg_sta   (cfg_sta),
        .cfg_sto   (cfg_sto),
        .t_upd     (t_upd),
        .t_low     (t_low),
        .t_smp     (t_smp),
        .t_bit     (t_bit),
        .t_sta_su  (t_sta_su),
        .t_sta_end (t_sta_end),
        .t_sto_end (t_sto_end)
    );

    i2c_tm_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_bit   (cmd_bit),
        .bus_free  (bus_free),
        .sda_in    (sda_in),
        .t_upd     (t_upd),
        .t_low     (t_low),
        .t_smp     (t_smp),
        .t_bit     (t_bit),
        .t_sta_su  (t_sta_su),
        .t_sta_end (t_sta_end),
        .t_sto_end (t_sto_end),
        .load      (load),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .rx_bit    (rx_bit),
        .done      (done),
        .err       (err)
    );

endmodule

// File: rtl/i2c_tm_chk.sv
`timescale 1ns/1ps
module i2c_tm_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic sda_oe,
    input logic rx_bit,
    input logic done,
    input logic err
);
    // R7: completion strobe lasts one clock
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a refusal never coincides with a completion
    a_r9_err_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !done);

    // R3: SDA update lies inside the low phase, never on the SCL release edge
    a_r3_sda_still_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_oe) |-> $stable(sda_oe));

    // R7: pulling SCL low is always the closing edge of an operation
    a_r7_scl_pull_ends_op: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> done);

    // R6: received data is only captured while SCL is released
    a_r6_rx_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_bit) |-> !scl_oe);
endmodule

bind i2c_bit_timer i2c_tm_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_oe (scl_oe),
    .sda_oe (sda_oe),
    .rx_bit (rx_bit),
    .done   (done),
    .err    (err)
);

// File: tb/i2c_bit_timer_tb.sv
`timescale 1ns/1ps
module i2c_bit_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_div = '0;
    logic [1:0]  cfg_upd = '0, cfg_sta = '0, cfg_sto = '0, cmd_op = '0;
    logic        cmd_valid = 1'b0, cmd_bit = 1'b0;
    logic        ext_scl_low = 1'b0, ext_sda_low = 1'b0;
    logic        scl_oe, sda_oe, rx_bit, done, err;
    logic [1:0]  pin_state;
    wire         scl_in = !scl_oe && !ext_scl_low;
    wire         sda_in = !sda_oe && !ext_sda_low;

    int tests = 0, fails = 0, cyc = 0;

    always #4 clk = ~clk;

    i2c_bit_timer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_upd(cfg_upd),
        .cfg_sta(cfg_sta), .cfg_sto(cfg_sto), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_bit(cmd_bit), .scl_in(scl_in), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .rx_bit(rx_bit), .done(done),
        .err(err), .pin_state(pin_state)
    );

    // ---------------- behavioural reference model ----------------
    int m_st, m_op, t, L, H, S, U, P;
    bit m_txb, m_own, m_scl, m_sda, m_done, m_err, m_rx, ln_scl, ln_sda;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_op = 0; t = 0; m_txb = 0; m_own = 0; m_scl = 0;
            m_sda = 0; m_done = 0; m_err = 0; m_rx = 0;
            L = 1; H = 1; S = 1; U = 1; P = 1;
        end else begin
            m_done = 0; m_err = 0;
            ln_scl = !m_scl && !ext_scl_low;
            ln_sda = !m_sda && !ext_sda_low;
            if (m_st == 0) begin
                if (cmd_valid) begin
                    if (cmd_op == 2'd0) begin
                        if (ln_scl && ln_sda) begin
                            L = int'(cfg_div[15:0]) + 1;
                            H = int'(cfg_div[31:16]) + 1;
                            S = ((int'(cfg_upd) > 2) ? 2 : int'(cfg_upd)) + 1;
                            U = int'(cfg_sta) + 1;
                            P = int'(cfg_sto) + 1;
                            m_st = 1; t = 0;
                        end else m_err = 1;
                    end else if (m_own) begin
                        m_st = (cmd_op == 2'd1) ? 2 : 3;
                        m_op = int'(cmd_op); m_txb = cmd_bit; t = 0;
                    end else m_err = 1;
                end
            end else begin
                t = t + 1;
                if (m_st == 1) begin
                    if (t == 8*H*U + 1) m_sda = 1;
                    if (t == 8*H*U + 8*H*(U+1)) begin
                        m_scl = 1; m_own = 1; m_done = 1; m_st = 0;
                    end
                end else if (m_st == 3) begin
                    if (t == L*S + 1) m_sda = (m_op == 2) ? !m_txb : 1'b0;
                    if (t == 8*L) m_scl = 0;
                    if (t == 8*L + 4*H && m_op == 3) m_rx = ln_sda;
                    if (t == 8*(L+H)) begin m_scl = 1; m_done = 1; m_st = 0; end
                end else begin
                    if (t == L*S + 1) m_sda = 1;
                    if (t == 8*L) m_scl = 0;
                    if (t == 8*L + 8*H*P + 1) begin
                        m_sda = 0; m_own = 0; m_done = 1; m_st = 0;
                    end
                end
            end
        end
    end

    // per-clock comparison, away from both edges
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            bit bad;
            bad = 0;
            tests++;
            if (scl_oe !== m_scl) begin bad = 1; $display("FAIL R2 scl_oe t=%0t got %0b expected %0b", $time, scl_oe, m_scl); end
            if (sda_oe !== m_sda) begin bad = 1; $display("FAIL R3 sda_oe t=%0t got %0b expected %0b", $time, sda_oe, m_sda); end
            if (done !== m_done) begin bad = 1; $display("FAIL R7 done t=%0t got %0b expected %0b", $time, done, m_done); end
            if (err !== m_err) begin bad = 1; $display("FAIL R9 err t=%0t got %0b expected %0b", $time, err, m_err); end
            if (rx_bit !== m_rx) begin bad = 1; $display("FAIL R6 rx_bit t=%0t got %0b expected %0b", $time, rx_bit, m_rx); end
            if (pin_state !== {m_scl || ext_scl_low, m_sda || ext_sda_low}) begin
                bad = 1;
                $display("FAIL R8 pin_state t=%0t got %0d expected %0d", $time, pin_state,
                         {m_scl || ext_scl_low, m_sda || ext_sda_low});
            end
            if (bad) fails++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired got %0d cycles expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s got %0d expected %0d", tag, act, exp);
        end
    endtask

    // issue a command at the current negedge; report edge indices (0 = accept edge)
    task automatic run_cmd(input int op, input bit b, input int inj_at,
                           output int k_done, output int k_err,
                           output int k_sda, output int k_scl);
        bit p_sda, p_scl;
        cmd_valid = 1; cmd_op = 2'(op); cmd_bit = b;
        p_sda = sda_oe; p_scl = scl_oe;
        k_done = -1; k_err = -1; k_sda = -1; k_scl = -1;
        for (int n = 1; n < 3000; n++) begin
            @(negedge clk);
            if (n == 1) cmd_valid = 0;
            if (n == inj_at) begin cmd_valid = 1; cmd_op = 2'd1; end
            else if (n == inj_at + 1) cmd_valid = 0;
            if (k_sda < 0 && sda_oe != p_sda) k_sda = n - 1;
            if (k_scl < 0 && scl_oe != p_scl) k_scl = n - 1;
            if (err)  begin k_err = n - 1; break; end
            if (done) begin k_done = n - 1; break; end
        end
    endtask

    initial begin
        int kd, ke, ks, kc;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 scl_oe after reset", scl_oe, 0);
        check("R1 sda_oe after reset", sda_oe, 0);
        check("R1 done after reset", done, 0);
        check("R1 err after reset", err, 0);
        check("R1 rx_bit after reset", rx_bit, 0);

        // bit operation without a start is refused
        run_cmd(2, 1, -1, kd, ke, ks, kc);
        check("R9 send without start err edge", ke, 0);
        check("R9 send without start no done", kd, -1);

        // line status codes
        ext_sda_low = 1; @(negedge clk);
        check("R8 SDA low code", pin_state, 1);
        ext_scl_low = 1; @(negedge clk);
        check("R8 both low code", pin_state, 3);
        ext_sda_low = 0; @(negedge clk);
        check("R8 SCL low code", pin_state, 2);
        ext_scl_low = 0; ext_sda_low = 1; @(negedge clk);
        run_cmd(0, 0, -1, kd, ke, ks, kc);
        check("R9 start with SDA held low err", ke, 0);
        check("R9 start refused leaves sda_oe", sda_oe, 0);
        check("R9 start refused leaves scl_oe", scl_oe, 0);
        ext_sda_low = 0; @(negedge clk);

        // configuration A: l=2 h=3 s=2 u=2 p=1
        cfg_div = {16'd2, 16'd1}; cfg_upd = 2'd1; cfg_sta = 2'd1; cfg_sto = 2'd0;
        run_cmd(0, 0, -1, kd, ke, ks, kc);
        check("R4 start SDA fall edge", ks, 49);
        check("R4 start done edge", kd, 120);
        check("R7 start SCL pull on done edge", kc, 120);
        @(negedge clk);
        check("R7 done drops after one clock", done, 0);

        run_cmd(2, 1, -1, kd, ke, ks, kc);
        check("R3 send SDA update edge", ks, 5);
        check("R2 SCL release edge", kc, 16);
        check("R2 bit done edge", kd, 40);

        run_cmd(3, 0, -1, kd, ke, ks, kc);
        check("R6 receive high", rx_bit, 1);
        check("R2 receive done edge", kd, 40);
        ext_sda_low = 1;
        run_cmd(3, 0, -1, kd, ke, ks, kc);
        check("R6 receive low", rx_bit, 0);
        ext_sda_low = 0;

        // R10: reprogram mid-transfer, old timing must persist
        cfg_div = {16'd5, 16'd3}; cfg_upd = 2'd0;
        run_cmd(2, 0, -1, kd, ke, ks, kc);
        check("R10 update edge keeps old values", ks, 5);
        check("R10 done edge keeps old values", kd, 40);

        // R11: stop request while a bit is in flight
        run_cmd(2, 1, 8, kd, ke, ks, kc);
        check("R11 update edge unaffected", ks, 5);
        check("R11 done edge unaffected", kd, 40);
        check("R11 no err from busy command", ke, -1);
        repeat (20) @(negedge clk);
        check("R11 ignored stop left SCL held", scl_oe, 1);
        check("R11 ignored stop left SDA released", sda_oe, 0);

        run_cmd(1, 0, -1, kd, ke, ks, kc);
        check("R5 stop SDA low edge", ks, 5);
        check("R5 stop SCL release edge", kc, 16);
        check("R5 stop done edge", kd, 41);
        check("R5 SDA released after stop", sda_oe, 0);

        run_cmd(3, 0, -1, kd, ke, ks, kc);
        check("R9 receive after stop refused", ke, 0);

        // configuration B: l=1 h=1 upd 3 clamps to s=3, u=1, p=3
        cfg_div = '0; cfg_upd = 2'd3; cfg_sta = 2'd0; cfg_sto = 2'd2;
        @(negedge clk);
        run_cmd(0, 0, -1, kd, ke, ks, kc);
        check("R4 start B SDA fall edge", ks, 9);
        check("R4 start B done edge", kd, 24);
        run_cmd(2, 1, -1, kd, ke, ks, kc);
        check("R3 clamped update edge", ks, 4);
        check("R2 B SCL release edge", kc, 8);
        check("R2 B done edge", kd, 16);
        run_cmd(3, 0, -1, kd, ke, ks, kc);
        check("R6 B receive high", rx_bit, 1);
        run_cmd(1, 0, -1, kd, ke, ks, kc);
        check("R5 B stop SDA low edge", ks, 4);
        check("R5 B stop done edge", kd, 33);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule